// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block sits between the command decoder of a synchronous DRAM model or controller and the column path of the array. When a Read or Write command is accepted it sequences the column address of every burst beat, one beat per clock, starting in the command's own clock. The sequence follows the programmed burst length, ordering and write mode. Finite bursts wrap inside their aligned block. A whole-row burst wraps around the row and runs until it is stopped or replaced.

Alongside the address it produces the per-byte-lane write strobes, masked by DQM in the same clock. For reads it produces a data-valid strobe delayed by the CAS latency, and per-lane output enables that open one clock before the first data word. Each of those enables is closed by DQM with a two-clock delay. The array itself is not part of the block.

Top module: `sdram_burst_colgen`

## Requirements
- R1: In the clock where `cmd_start` is high, `beat_valid` is high and `col_addr` equals `cmd_col`. Following beats come one per clock, and no beat is produced after reset until a command arrives.
- R2: With sequential ordering (`mode_interleave` = 0) and a burst of length L in {2,4,8}, beat k addresses the start column with its low log2(L) bits replaced by (start + k) mod L. The upper bits stay fixed for the whole burst.
- R3: With interleaved ordering (`mode_interleave` = 1) and L in {2,4,8}, the low log2(L) bits of beat k are the start's low bits XOR k, and the upper bits stay fixed.
- R4: Burst length code 3'b000 gives exactly one beat at the start column, and `mode_interleave` has no effect on it.
- R5: Burst length code 3'b111 selects a whole-row burst. Beat k addresses (start + k) mod 2^COL_W, `mode_interleave` is ignored, and beats continue until burst stop or a new command.
- R6: When `mode_single_write` = 1, a write produces exactly one beat at the start column, whatever the burst length. Reads keep their full length.
- R7: Length codes 3'b001, 3'b010 and 3'b011 give bursts of 2, 4 and 8 beats. `beat_valid` is low in the clock after the last beat when no new command arrives.
- R8: `burst_stop` high without `cmd_start` removes the beat of that clock and all later beats of the burst. Write strobes are therefore low in that same clock, and read data valid stops CAS latency clocks later. `cmd_start` in the same clock takes precedence over `burst_stop`.
- R9: A command during a running burst ends the old burst at once. The new burst's beat 0 appears in that clock, whether the old burst was a read or a write.
- R10: `rd_data_valid` is high exactly CL clocks after each read beat. CL is 3 when `mode_cas` = 2'b11 and 2 otherwise.
- R11: `rd_oe[i]` is high in every clock where `rd_data_valid` is high and in the clock before each read data word. It is forced low when `dqm[i]` was high two clocks earlier.
- R12: `wr_en[i]` is high exactly when a write beat is present in the clock and `dqm[i]` is low in that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Read or Write command accepted in this clock |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_col | input | COL_W | Starting column of the command |
| mode_blen | input | 3 | Burst length code: 000=1, 001=2, 010=4, 011=8, 111=whole row, others=1 |
| mode_interleave | input | 1 | 0 = sequential ordering, 1 = interleaved ordering |
| mode_single_write | input | 1 | 1 = writes last one beat |
| mode_cas | input | 2 | CAS latency select: 2'b11 = 3 clocks, otherwise 2 |
| burst_stop | input | 1 | Terminate the running burst |
| dqm | input | LANES | Per-lane data mask |
| col_addr | output | COL_W | Column of the current beat |
| beat_valid | output | 1 | A beat is present in this clock |
| wr_en | output | LANES | Per-lane write strobe |
| rd_data_valid | output | 1 | Read data word presented in this clock |
| rd_oe | output | LANES | Per-lane output driver enable |

## Verification
The hardest situations to reach from the ports are the overlaps. These include a burst cut short by a new command of the other direction, and a stop or a DQM pulse landing while read beats are still inside the latency pipeline. The bench sweeps every length, ordering, start alignment, direction and latency back to back. It drives a DQM pattern whose periods are coprime, so masks fall on every position of the pipeline. It then chains truncated bursts into new commands and issues stops in mid-burst and in the command clock. Every clock, a bench-side history of expected read beats and DQM values predicts the delayed strobes.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

    // Burst length codes; any code not listed behaves as a single beat
    typedef enum logic [2:0] {
        BL_ONE   = 3'b000,
        BL_TWO   = 3'b001,
        BL_FOUR  = 3'b010,
        BL_EIGHT = 3'b011,
        BL_ROW   = 3'b111
    } blen_code_e;

    localparam logic [1:0] CAS_THREE = 2'b11;

    function automatic logic [1:0] blen_log2(input logic [2:0] code);
        case (code)
            BL_TWO:   return 2'd1;
            BL_FOUR:  return 2'd2;
            BL_EIGHT: return 2'd3;
            default:  return 2'd0;
        endcase
    endfunction

    function automatic logic is_row_burst(input logic [2:0] code);
        return code == BL_ROW;
    endfunction

endpackage

// File: rtl/sdr_burst_order.sv
module sdr_burst_order #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] idx,
    input  logic [COL_W-1:0] mask,
    input  logic             interleave,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] low;

    always_comb begin
        // wrap inside the aligned block selected by mask
        low = interleave ? (base ^ idx) : (base + idx);
        col = (base & ~mask) | (low & mask);
    end
endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
    import sdr_burst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic             cmd_write,
    input  logic [COL_W-1:0] cmd_col,
    input  logic [2:0]       mode_blen,
    input  logic             mode_interleave,
    input  logic             mode_single_write,
    input  logic             burst_stop,
    output logic             beat_valid,
    output logic             beat_write,
    output logic [COL_W-1:0] beat_base,
    output logic [COL_W-1:0] beat_idx,
    output logic [COL_W-1:0] beat_mask,
    output logic             beat_interleave
);
    typedef struct packed {
        logic             active;
        logic             write;
        logic             row;
        logic             il;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] idx;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] lim;
    } seq_t;

    seq_t st_q, st_d;

    logic             c_row;
    logic             c_single;
    logic             c_il;
    logic [COL_W-1:0] c_mask;
    logic [COL_W-1:0] c_lim;

    always_comb begin
        // decode the mode fields seen with a new command
        c_row    = is_row_burst(mode_blen);
        c_single = cmd_write & mode_single_write;
        c_mask   = c_row ? '1 : COL_W'((32'd1 << blen_log2(mode_blen)) - 32'd1);
        c_il     = mode_interleave & ~c_row;
        c_lim    = c_single ? '0 : c_mask;

        // beat of the current clock
        beat_valid      = 1'b0;
        beat_write      = st_q.write;
        beat_base       = st_q.base;
        beat_idx        = st_q.idx;
        beat_mask       = st_q.mask;
        beat_interleave = st_q.il;
        if (cmd_start) begin
            beat_valid      = 1'b1;
            beat_write      = cmd_write;
            beat_base       = cmd_col;
            beat_idx        = '0;
            beat_mask       = c_mask;
            beat_interleave = c_il;
        end else if (st_q.active && !burst_stop) begin
            beat_valid = 1'b1;
        end

        // next state
        st_d = st_q;
        if (cmd_start) begin
            st_d.row    = c_row & ~c_single;
            st_d.active = (c_row & ~c_single) | (c_lim != '0);
            st_d.write  = cmd_write;
            st_d.il     = c_il;
            st_d.base   = cmd_col;
            st_d.idx    = COL_W'(1);
            st_d.mask   = c_mask;
            st_d.lim    = c_lim;
        end else if (st_q.active) begin
            if (burst_stop) begin
                st_d.active = 1'b0;
            end else begin
                st_d.active = st_q.row | (st_q.idx != st_q.lim);
                st_d.idx    = st_q.idx + COL_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_stop && !cmd_start) |=> (!beat_valid || cmd_start));

    assert_single_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && cmd_write && mode_single_write) |=> (!beat_valid || cmd_start));
endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_beat,
    input  logic             cas3,
    input  logic [LANES-1:0] dqm,
    output logic             rd_valid,
    output logic [LANES-1:0] rd_oe
);
    localparam int DEPTH = 3;

    typedef struct packed {
        logic [DEPTH-1:0] hist;
        logic [LANES-1:0] m1;
        logic [LANES-1:0] m2;
    } pipe_t;

    pipe_t pp_q, pp_d;
    logic  lead;

    always_comb begin
        // hist[n] holds the read beat of n+1 clocks ago
        pp_d.hist = {pp_q.hist[DEPTH-2:0], rd_beat};
        pp_d.m1   = dqm;
        pp_d.m2   = pp_q.m1;
        rd_valid  = cas3 ? pp_q.hist[2] : pp_q.hist[1];
        lead      = cas3 ? pp_q.hist[1] : pp_q.hist[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pp_q <= '0;
        else        pp_q <= pp_d;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign rd_oe[i] = (rd_valid | lead) & ~pp_q.m2[i];

        assert_oe_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
            $past(dqm[i], 2) |-> !rd_oe[i]);
    end

    assert_rd_lat2_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas3 && !$past(cas3) && !$past(cas3, 2)) |-> (rd_valid == $past(rd_beat, 2)));

    assert_rd_lat3_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cas3 && $past(cas3) && $past(cas3, 2) && $past(cas3, 3))
            |-> (rd_valid == $past(rd_beat, 3)));
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import sdr_burst_pkg::*;
#(
    parameter int COL_W = 8,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic             cmd_write,
    input  logic [COL_W-1:0] cmd_col,
    input  logic [2:0]       mode_blen,
    input  logic             mode_interleave,
    input  logic             mode_single_write,
    input  logic [1:0]       mode_cas,
    input  logic             burst_stop,
    input  logic [LANES-1:0] dqm,
    output logic [COL_W-1:0] col_addr,
    output logic             beat_valid,
    output logic [LANES-1:0] wr_en,
    output logic             rd_data_valid,
    output logic [LANES-1:0] rd_oe
);
    logic             beat_write;
    logic [COL_W-1:0] beat_base;
    logic [COL_W-1:0] beat_idx;
    logic [COL_W-1:0] beat_mask;
    logic             beat_il;
    logic             rd_beat;

    sdr_burst_seq #(.COL_W(COL_W)) u_seq (
        .clk               (clk),
        .rst_n             (rst_n),
        .cmd_start         (cmd_start),
        .cmd_write         (cmd_write),
        .cmd_col           (cmd_col),
        .mode_blen         (mode_blen),
        .mode_interleave   (mode_interleave),
        .mode_single_write (mode_single_write),
        .burst_stop        (burst_stop),
        .beat_valid        (beat_valid),
        .beat_write        (beat_write),
        .beat_base         (beat_base),
        .beat_idx          (beat_idx),
        .beat_mask         (beat_mask),
        .beat_interleave   (beat_il)
    );

    sdr_burst_order #(.COL_W(COL_W)) u_order (
        .base       (beat_base),
        .idx        (beat_idx),
        .mask       (beat_mask),
        .interleave (beat_il),
        .col        (col_addr)
    );

    assign rd_beat = beat_valid & ~beat_write;

    sdr_rd_pipe #(.LANES(LANES)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_beat  (rd_beat),
        .cas3     (mode_cas == CAS_THREE),
        .dqm      (dqm),
        .rd_valid (rd_data_valid),
        .rd_oe    (rd_oe)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_wr
        assign wr_en[i] = beat_valid & beat_write & ~dqm[i];
    end

    assert_block_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !cmd_start) |-> ((col_addr & ~beat_mask) == (beat_base & ~beat_mask)));
endmodule

// File: tb/tb_sdram_burst_colgen.sv
`timescale 1ns/1ps
module tb_sdram_burst_colgen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_start = 1'b0;
    logic       cmd_write = 1'b0;
    logic [7:0] cmd_col = 8'd0;
    logic [2:0] mode_blen = 3'd0;
    logic       mode_interleave = 1'b0;
    logic       mode_single_write = 1'b0;
    logic [1:0] mode_cas = 2'b10;
    logic       burst_stop = 1'b0;
    logic [1:0] dqm = 2'b00;
    logic [7:0] col_addr;
    logic       beat_valid;
    logic [1:0] wr_en;
    logic       rd_data_valid;
    logic [1:0] rd_oe;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  cyc     = 0;
    bit  done    = 0;

    // mode used by stimulus and model
    int  m_lg = 0;
    bit  m_page = 0, m_il = 0, m_sw = 0, m_cas3 = 0;

    // model history: expected read beats of past clocks, DQM of past clocks
    logic [2:0] rdh = 3'b000;
    logic [1:0] dqh1 = 2'b00, dqh2 = 2'b00;

    always #4 clk = ~clk;

    sdram_burst_colgen dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_write(cmd_write),
        .cmd_col(cmd_col), .mode_blen(mode_blen), .mode_interleave(mode_interleave),
        .mode_single_write(mode_single_write), .mode_cas(mode_cas),
        .burst_stop(burst_stop), .dqm(dqm), .col_addr(col_addr),
        .beat_valid(beat_valid), .wr_en(wr_en), .rd_data_valid(rd_data_valid),
        .rd_oe(rd_oe)
    );

    task automatic chk(input int act, input int exp, input string tag, input string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    function automatic logic [7:0] exp_col(input logic [7:0] s, input int k);
        int si, len, blk, off, o2;
        si = int'(s);
        if (m_page) return 8'((si + k) % 256);
        len = 1 << m_lg;
        blk = si - (si % len);
        off = si % len;
        if (m_il) o2 = off ^ (k % len);
        else      o2 = (off + k) % len;
        return 8'(blk + o2);
    endfunction

    task automatic step(input logic st, input logic wr, input logic [7:0] c, input logic stp,
                        input logic eb, input logic [7:0] ec, input logic ew, input string tag);
        logic [1:0] dq, exp_wr, exp_oe;
        logic rv, lead;
        @(negedge clk);
        cyc++;
        dq = (cyc % 5 == 2) ? 2'b01 : (cyc % 7 == 3) ? 2'b10 : (cyc % 11 == 0) ? 2'b11 : 2'b00;
        cmd_start = st; cmd_write = wr; cmd_col = c; burst_stop = stp; dqm = dq;
        mode_blen = m_page ? 3'b111 : 3'(m_lg);
        mode_interleave = m_il; mode_single_write = m_sw;
        mode_cas = m_cas3 ? 2'b11 : 2'b10;
        #1;
        chk(int'(beat_valid), int'(eb), tag, "beat_valid");
        if (eb) chk(int'(col_addr), int'(ec), tag, "col_addr");
        exp_wr = (eb && ew) ? ~dq : 2'b00;
        chk(int'(wr_en), int'(exp_wr), "R12", "wr_en");
        rv   = m_cas3 ? rdh[2] : rdh[1];
        lead = m_cas3 ? rdh[1] : rdh[0];
        chk(int'(rd_data_valid), int'(rv), "R10", "rd_data_valid");
        exp_oe = (rv || lead) ? ~dqh2 : 2'b00;
        chk(int'(rd_oe), int'(exp_oe), "R11", "rd_oe");
        rdh  = {rdh[1:0], eb && !ew};
        dqh2 = dqh1;
        dqh1 = dq;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'd0, 1'b0, 1'b0, 8'd0, 1'b0, tag);
    endtask

    // nb > 0 truncates the burst (stop or chained command follows)
    task automatic burst(input logic [7:0] s, input logic wr, input int nb,
                         input logic do_stop, input logic chain, input string tag);
        int full, n;
        string t;
        full = (wr && m_sw) ? 1 : (m_page ? 1000000 : (1 << m_lg));
        n = (nb > 0 && nb < full) ? nb : full;
        for (int k = 0; k < n; k++) begin
            if (k == 0 && n > 1 && tag != "R9") t = "R1";
            else t = tag;
            step(k == 0, wr, s, 1'b0, 1'b1, exp_col(s, k), wr, t);
        end
        if (do_stop) step(1'b0, wr, 8'd0, 1'b1, 1'b0, 8'd0, wr, "R8");
        if (!chain) begin
            if (n == full) t = "R7";
            else t = "R8";
            step(1'b0, 1'b0, 8'd0, 1'b0, 1'b0, 8'd0, 1'b0, t);
        end
    endtask

    initial begin
        logic [7:0] starts [8];
        string tg;
        starts = '{8'h00, 8'h01, 8'h03, 8'h05, 8'h06, 8'h07, 8'h9C, 8'hFF};

        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(int'(beat_valid), 0, "R1", "beat_valid in reset");
        chk(int'(rd_data_valid), 0, "R10", "rd_data_valid in reset");
        chk(int'(rd_oe), 0, "R11", "rd_oe in reset");
        rst_n = 1'b1;
        idle(3, "R1");

        // sweep: latency x length x ordering x direction x start alignment
        for (int cl = 0; cl < 2; cl++) begin
            m_cas3 = (cl == 1);
            idle(4, "R10");
            for (int lg = 0; lg < 4; lg++) begin
                for (int il = 0; il < 2; il++) begin
                    for (int wr = 0; wr < 2; wr++) begin
                        for (int si = 0; si < 8; si++) begin
                            m_lg = lg; m_il = (il == 1); m_page = 0; m_sw = 0;
                            if (lg == 0) tg = "R4";
                            else if (il == 1) tg = "R3";
                            else tg = "R2";
                            burst(starts[si], wr == 1, 0, 1'b0, 1'b0, tg);
                        end
                    end
                end
            end
        end

        // R6: single write mode
        m_page = 0; m_il = 0; m_lg = 3; m_sw = 1;
        burst(8'h05, 1'b1, 0, 1'b0, 1'b0, "R6");
        burst(8'h05, 1'b0, 0, 1'b0, 1'b0, "R6");
        m_page = 1;
        burst(8'h40, 1'b1, 0, 1'b0, 1'b0, "R6");
        m_sw = 0;

        // R5: whole-row bursts across the row end, interleave bit ignored
        m_page = 1; m_il = 1;
        burst(8'hFA, 1'b1, 10, 1'b1, 1'b0, "R5");
        m_cas3 = 1; idle(4, "R10");
        burst(8'hFE, 1'b0, 6, 1'b1, 1'b0, "R5");
        m_cas3 = 0; idle(4, "R10");
        burst(8'hFC, 1'b0, 7, 1'b1, 1'b0, "R5");
        m_il = 0; m_page = 0;

        // R8: stop mid finite bursts
        m_lg = 3;
        burst(8'h03, 1'b0, 3, 1'b1, 1'b0, "R8");
        burst(8'h04, 1'b1, 2, 1'b1, 1'b0, "R8");
        m_cas3 = 1; idle(4, "R10");
        burst(8'h0B, 1'b0, 5, 1'b1, 1'b0, "R8");
        m_cas3 = 0; idle(4, "R10");

        // R8: command wins over stop in the same clock
        m_lg = 2;
        step(1'b1, 1'b0, 8'h12, 1'b1, 1'b1, exp_col(8'h12, 0), 1'b0, "R8");
        for (int k = 1; k < 4; k++)
            step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, exp_col(8'h12, k), 1'b0, "R8");
        idle(1, "R7");

        // R9: interruptions in all direction pairs
        m_lg = 3;
        burst(8'h03, 1'b0, 3, 1'b0, 1'b1, "R2");
        burst(8'h40, 1'b0, 0, 1'b0, 1'b0, "R9");
        burst(8'h10, 1'b1, 2, 1'b0, 1'b1, "R2");
        burst(8'h21, 1'b1, 0, 1'b0, 1'b0, "R9");
        m_il = 1;
        burst(8'h36, 1'b1, 4, 1'b0, 1'b1, "R3");
        burst(8'h55, 1'b0, 0, 1'b0, 1'b0, "R9");
        m_cas3 = 1; idle(4, "R10");
        burst(8'h77, 1'b0, 1, 1'b0, 1'b1, "R3");
        burst(8'h81, 1'b1, 0, 1'b0, 1'b0, "R9");
        idle(5, "R10");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule